// File: doc/BRIEF.md
# Transmit I/Q Source Selector

This block feeds transmit I/Q sample pairs to the radio interface. The radio side pulls one pair per cycle in which it raises a sample strobe. Two sources can supply that pair. The first is a built-in quadrature tone that repeats a four-pair cycle. The second is a stream engine that masters Wishbone read cycles over a buffer in memory and passes the words on as samples.

After reset the block outputs the tone, which gives a known signal as soon as the radio starts pulling samples. Software programs a buffer word address and a length in words, then writes a start bit. Setting the source select bit switches the output to the buffered stream. When the whole buffer has gone out, the block raises an interrupt. The interrupt stays high until software clears it.

A small FIFO sits between the bus side and the sample side. Bus wait states therefore have no effect on the samples until the FIFO runs dry. If it does run dry, zeros go out and a sticky flag records the underrun.

Top module: `tx_src_sel`

## Requirements
- R1: After reset, `tx_i_o`, `tx_q_o` and `irq_o` are 0, `wb_cyc_o`, `wb_stb_o` and `wb_we_o` are 0, the status register reads 0, and the source select is the tone.
- R2: In tone mode, strobes produce the signed pairs (+A,0), (0,+A), (-A,0), (0,-A) in that order and then repeat, where A is `TONE_AMP`. The tone phase advances only on strobes served by the tone. Its period of four strobes places the tone at one quarter of the strobe rate.
- R3: The outputs are registered and change only at a clock edge where `smp_en_i` is high. The source select is sampled at that edge, so a change of source takes effect on a whole pair, namely the first strobe after the write.
- R4: Register map at `reg_addr_i`:
  - 0 is control: bit 0 selects the source (0 tone, 1 stream) and bit 1 starts a transfer when written as 1.
  - 1 is the buffer base word address.
  - 2 is the length in words.
  - 3 is status: bit 0 busy, bit 1 done, bit 2 underrun.
  - `reg_rdata_o` shows the addressed register in the same cycle.
- R5: The stream engine issues read cycles (`wb_we_o` = 0) to word addresses base, base+1, and so on. Each read keeps `wb_stb_o` high and `wb_adr_o` stable until `wb_ack_i`.
- R6: In stream mode, each strobe pops the next buffered word. Bits 31:16 of the word go to I and bits 15:0 go to Q.
- R7: Fetching pauses while the FIFO (`FIFO_DEPTH` words) is full. Fetching also runs while the tone is selected.
- R8: In stream mode, a strobe that finds the FIFO empty outputs (0,0). If a transfer is busy at that strobe, status bit 2 is set and stays set.
- R9: After LEN pairs have been output, busy clears and done and `irq_o` are set. A start with length 0 sets done at once.
- R10: A start written while busy is ignored. Base and length values written during a transfer do not affect it.
- R11: Writing 1 to status bit 1 or bit 2 clears that bit, and `irq_o` follows done. If a clear of done falls in the same cycle as the final sample, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_en_i | input | 1 | Sample strobe from the radio side |
| tx_i_o | output | SMP_W | In-phase sample |
| tx_q_o | output | SMP_W | Quadrature sample |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable, always 0 |
| wb_adr_o | output | ADR_W | Wishbone word address |
| wb_dat_i | input | 2*SMP_W | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| irq_o | output | 1 | Transfer-complete interrupt |

## Verification
Two events can land on the same edge: the strobe that emits the last buffered pair sets done, and a software write of 1 to the done bit clears it. The bench drives a status clear in the same cycle as the final stream strobe. It then expects done and `irq_o` to read 1, because the set takes priority. A second clear, made later on its own, must drop them. The bench also stalls the bus acknowledge while a transfer is busy, so that an underrun strobe and a second start write both arrive while the FIFO is empty.

// File: rtl/tx_src_pkg.sv
package tx_src_pkg;
  localparam int REG_W = 32;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_BASE = 2'd1;
  localparam logic [1:0] REG_LEN  = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;
  localparam int CTRL_SEL   = 0;
  localparam int CTRL_START = 1;
  localparam int STAT_BUSY  = 0;
  localparam int STAT_DONE  = 1;
  localparam int STAT_UNF   = 2;
  typedef enum logic {SRC_TONE = 1'b0, SRC_STREAM = 1'b1} src_e;
endpackage

// File: rtl/tx_tone_gen.sv
module tx_tone_gen #(
  parameter int W   = 16,
  parameter int AMP = 8192
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] i_o,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] POS = AMP[W-1:0];
  localparam logic [W-1:0] NEG = -POS;

  logic [1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= '0;
    else if (adv_i) phase_q <= phase_q + 2'd1;
  end

  always_comb begin
    unique case (phase_q)
      2'd0:    begin i_o = POS; q_o = '0;  end
      2'd1:    begin i_o = '0;  q_o = POS; end
      2'd2:    begin i_o = NEG; q_o = '0;  end
      default: begin i_o = '0;  q_o = NEG; end
    endcase
  end
endmodule

// File: rtl/tx_sample_fifo.sv
module tx_sample_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [PW:0]   FULL = (PW + 1)'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [PW:0]   cnt_q;
  logic          do_push, do_pop;

  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL);
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + (PW + 1)'(do_push) - (PW + 1)'(do_pop);
    end
  end
endmodule

// File: rtl/tx_wb_reader.sv
module tx_wb_reader #(
  parameter int ADR_W = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ADR_W-1:0] base_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             room_i,
  output logic             wb_cyc_o,
  output logic             wb_stb_o,
  output logic [ADR_W-1:0] wb_adr_o,
  input  logic             wb_ack_i,
  output logic             push_o
);
  logic [ADR_W-1:0] adr_q;
  logic [LEN_W-1:0] left_q;
  logic             req_q;

  assign wb_cyc_o = req_q;
  assign wb_stb_o = req_q;
  assign wb_adr_o = adr_q;
  assign push_o   = req_q && wb_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_q  <= '0;
      left_q <= '0;
      req_q  <= 1'b0;
    end else if (start_i) begin
      adr_q  <= base_i;
      left_q <= len_i;
      req_q  <= 1'b0;
    end else if (req_q && wb_ack_i) begin
      req_q  <= 1'b0;
      adr_q  <= adr_q + 1'b1;
      left_q <= left_q - 1'b1;
    end else if (!req_q && left_q != '0 && room_i) begin
      req_q  <= 1'b1;  // one read in flight; room checked at issue
    end
  end
endmodule

// File: rtl/tx_src_sel.sv
module tx_src_sel
  import tx_src_pkg::*;
#(
  parameter int SMP_W      = 16,
  parameter int ADR_W      = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int TONE_AMP   = 8192
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               smp_en_i,
  output logic [SMP_W-1:0]   tx_i_o,
  output logic [SMP_W-1:0]   tx_q_o,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               wb_cyc_o,
  output logic               wb_stb_o,
  output logic               wb_we_o,
  output logic [ADR_W-1:0]   wb_adr_o,
  input  logic [2*SMP_W-1:0] wb_dat_i,
  input  logic               wb_ack_i,
  output logic               irq_o
);
  localparam int DW = 2 * SMP_W;

  src_e             sel_q;
  logic [ADR_W-1:0] base_q;
  logic [LEN_W-1:0] len_q, out_left_q;
  logic             busy_q, done_q, unf_q;
  logic [SMP_W-1:0] tone_i, tone_q;
  logic [DW-1:0]    fifo_rd;
  logic             fifo_empty, fifo_full, fifo_push, fifo_pop;
  logic             tone_adv, wr_ctrl, wr_stat, start_ok, fetch_start;

  assign wr_ctrl     = reg_we_i && reg_addr_i == REG_CTRL;
  assign wr_stat     = reg_we_i && reg_addr_i == REG_STAT;
  assign start_ok    = wr_ctrl && reg_wdata_i[CTRL_START] && !busy_q;
  assign fetch_start = start_ok && len_q != '0;
  assign tone_adv    = smp_en_i && sel_q == SRC_TONE;
  assign fifo_pop    = smp_en_i && sel_q == SRC_STREAM && busy_q && !fifo_empty;
  assign wb_we_o     = 1'b0;
  assign irq_o       = done_q;

  tx_tone_gen #(.W(SMP_W), .AMP(TONE_AMP)) i_tone (
    .clk_i, .rst_ni, .adv_i(tone_adv), .i_o(tone_i), .q_o(tone_q)
  );

  tx_wb_reader #(.ADR_W(ADR_W), .LEN_W(LEN_W)) i_reader (
    .clk_i, .rst_ni,
    .start_i (fetch_start),
    .base_i  (base_q),
    .len_i   (len_q),
    .room_i  (!fifo_full),
    .wb_cyc_o, .wb_stb_o, .wb_adr_o, .wb_ack_i,
    .push_o  (fifo_push)
  );

  tx_sample_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .push_i  (fifo_push),
    .wdata_i (wb_dat_i),
    .pop_i   (fifo_pop),
    .rdata_o (fifo_rd),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= SRC_TONE;
      base_q     <= '0;
      len_q      <= '0;
      out_left_q <= '0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      unf_q      <= 1'b0;
      tx_i_o     <= '0;
      tx_q_o     <= '0;
    end else begin
      if (wr_ctrl) sel_q <= src_e'(reg_wdata_i[CTRL_SEL]);
      if (reg_we_i && reg_addr_i == REG_BASE) base_q <= reg_wdata_i[ADR_W-1:0];
      if (reg_we_i && reg_addr_i == REG_LEN)  len_q  <= reg_wdata_i[LEN_W-1:0];
      // clears first, sets below override
      if (wr_stat && reg_wdata_i[STAT_DONE]) done_q <= 1'b0;
      if (wr_stat && reg_wdata_i[STAT_UNF])  unf_q  <= 1'b0;
      if (start_ok) begin
        if (len_q == '0) done_q <= 1'b1;
        else begin
          busy_q     <= 1'b1;
          out_left_q <= len_q;
        end
      end
      if (smp_en_i) begin
        if (sel_q == SRC_TONE) begin
          tx_i_o <= tone_i;
          tx_q_o <= tone_q;
        end else if (fifo_pop) begin
          tx_i_o     <= fifo_rd[DW-1:SMP_W];
          tx_q_o     <= fifo_rd[SMP_W-1:0];
          out_left_q <= out_left_q - 1'b1;
          if (out_left_q == LEN_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          tx_i_o <= '0;
          tx_q_o <= '0;
          if (busy_q) unf_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_CTRL: reg_rdata_o[CTRL_SEL] = sel_q;
      REG_BASE: reg_rdata_o = REG_W'(base_q);
      REG_LEN:  reg_rdata_o = REG_W'(len_q);
      default: begin
        reg_rdata_o[STAT_BUSY] = busy_q;
        reg_rdata_o[STAT_DONE] = done_q;
        reg_rdata_o[STAT_UNF]  = unf_q;
      end
    endcase
  end
endmodule

// File: rtl/tx_src_sel_chk.sv
module tx_src_sel_chk #(
  parameter int SMP_W = 16,
  parameter int ADR_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_en_i,
  input logic [SMP_W-1:0] tx_i_o,
  input logic [SMP_W-1:0] tx_q_o,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             wb_cyc_o,
  input logic             wb_stb_o,
  input logic             wb_we_o,
  input logic [ADR_W-1:0] wb_adr_o,
  input logic             wb_ack_i,
  input logic             irq_o
);
  logic clr_done;
  assign clr_done = reg_we_i && reg_addr_i == 2'd3 && reg_wdata_i[1];

  // R3
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(smp_en_i) |-> $stable({tx_i_o, tx_q_o}));

  // R5
  stb_in_cyc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> (wb_cyc_o && !wb_we_o));

  // R5
  stb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_stb_o && !wb_ack_i) |=> (wb_stb_o && $stable(wb_adr_o)));

  // R11
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_done) |=> irq_o);

  // R9
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(smp_en_i || (reg_we_i && reg_addr_i == 2'd0 && reg_wdata_i[1])));
endmodule

bind tx_src_sel tx_src_sel_chk #(.SMP_W(SMP_W), .ADR_W(ADR_W)) i_chk (.*);

// File: tb/test_tx_src_sel.sv
module test_tx_src_sel;
  localparam int CLK_PERIOD = 10;
  localparam int AMP = 8192;

  logic        clk_i = 1'b0, rst_ni = 1'b0, smp_en_i = 1'b0;
  logic [15:0] tx_i_o, tx_q_o;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        wb_cyc_o, wb_stb_o, wb_we_o, wb_ack_i, irq_o;
  logic [31:0] wb_adr_o, wb_dat_i;
  logic        stall = 1'b0, strobed = 1'b0;
  int          checks = 0, fails = 0, acks = 0, phase = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tx_src_sel i_tx_src_sel (.*);

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {a[15:0] + 16'h1000, 16'hffff - a[15:0]};
  endfunction

  function automatic logic [31:0] tone(int ph);
    case (ph % 4)
      0: return {16'(AMP), 16'h0};
      1: return {16'h0, 16'(AMP)};
      2: return {16'(-AMP), 16'h0};
      default: return {16'h0, 16'(-AMP)};
    endcase
  endfunction

  assign wb_dat_i = mem_word(wb_adr_o);
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) wb_ack_i <= 1'b0;
    else wb_ack_i <= wb_cyc_o && wb_stb_o && !wb_ack_i && !stall;
  always @(posedge clk_i) if (wb_stb_o && wb_ack_i) acks <= acks + 1;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: one expected pair per strobe
  always @(posedge clk_i) strobed <= smp_en_i;
  always @(negedge clk_i) if (strobed) begin
    if (exp_q.size() == 0) chk(1'b0, "unexpected sample", {tx_i_o, tx_q_o}, 32'h0);
    else begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({tx_i_o, tx_q_o} == e, t, {tx_i_o, tx_q_o}, e);
    end
  end

  task automatic strobe(input logic [31:0] e, input string t);
    @(negedge clk_i);
    exp_q.push_back(e);
    tag_q.push_back(t);
    smp_en_i = 1'b1;
    @(negedge clk_i);
    smp_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 chk(reg_rdata_o == e, t, reg_rdata_o, e);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    chk({tx_i_o, tx_q_o} == 0, "R1 outputs in reset", {tx_i_o, tx_q_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({irq_o, wb_cyc_o, wb_stb_o, wb_we_o} == 0, "R1 irq/bus idle", {irq_o, wb_cyc_o, wb_stb_o, wb_we_o}, 0);
    rd(2'd3, 0, "R1 status zero");
    rd(2'd0, 0, "R1 select tone");

    // R2 tone sequence, R3 hold between strobes
    for (int k = 0; k < 6; k++) begin
      strobe(tone(phase), "R2 tone pair");
      phase++;
    end
    repeat (3) @(negedge clk_i);
    chk({tx_i_o, tx_q_o} == tone(phase - 1), "R3 held without strobe", {tx_i_o, tx_q_o}, tone(phase - 1));

    // R4 registers, R7 prefetch while tone selected
    wr(2'd1, 32'h100);
    wr(2'd2, 32'd6);
    rd(2'd1, 32'h100, "R4 base readback");
    rd(2'd2, 32'd6, "R4 len readback");
    wr(2'd0, 32'h2);
    repeat (30) @(negedge clk_i);
    chk(acks == 4, "R7 fetch stops at fifo depth", acks, 4);
    rd(2'd3, 32'h1, "R4 busy set");

    // R6 stream words, R11 clear collides with final sample
    wr(2'd0, 32'h1);
    for (int k = 0; k < 5; k++) strobe(mem_word(32'h100 + k), "R6 stream word R5 address order");
    @(negedge clk_i);
    exp_q.push_back(mem_word(32'h105));
    tag_q.push_back("R6 last word");
    smp_en_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 2'd3; reg_wdata_i = 32'h2;
    @(negedge clk_i);
    smp_en_i = 1'b0; reg_we_i = 1'b0;
    rd(2'd3, 32'h2, "R11 set wins over clear R9 done");
    chk(irq_o == 1'b1, "R9 irq on completion", irq_o, 1);
    strobe(0, "R8 idle stream outputs zero");
    rd(2'd3, 32'h2, "R8 no underrun when idle");
    wr(2'd3, 32'h2);
    chk(irq_o == 1'b0, "R11 irq cleared", irq_o, 0);

    // R8 underrun, R10 start while busy
    stall = 1'b1;
    wr(2'd1, 32'h200);
    wr(2'd2, 32'd3);
    wr(2'd0, 32'h3);
    repeat (4) @(negedge clk_i);
    strobe(0, "R8 underrun zero pair");
    rd(2'd3, 32'h5, "R8 underrun sticky busy");
    wr(2'd1, 32'h300);
    wr(2'd2, 32'd5);
    wr(2'd0, 32'h3);
    stall = 1'b0;
    repeat (20) @(negedge clk_i);
    for (int k = 0; k < 3; k++) strobe(mem_word(32'h200 + k), "R10 original buffer kept");
    rd(2'd3, 32'h6, "R10 original length kept");
    strobe(0, "R10 no extra words");

    // R11 clear both
    wr(2'd3, 32'h6);
    rd(2'd3, 32'h0, "R11 w1c clears");

    // R3 source switch on next whole pair
    wr(2'd0, 32'h0);
    strobe(tone(phase), "R3 switch back to tone");
    phase++;

    // R9 zero-length start
    wr(2'd2, 32'd0);
    wr(2'd0, 32'h2);
    rd(2'd3, 32'h2, "R9 zero length done");
    chk(irq_o == 1'b1, "R9 zero length irq", irq_o, 1);

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule